// File: doc/BRIEF.md
# Fractional-N Modulus and Phase-Select Controller

This block controls a dual-modulus divider so that the average division ratio is an integer N plus a fraction in quarters. Every input clock cycle stands for one oscillator period. A down-counter produces a one-cycle divided pulse and reloads with either N or N+1. At each divided pulse a two-bit modulo-4 accumulator adds the fraction. Its carry becomes the modulus-control bit, and that bit sets the length of the next divided period.

The same accumulator value is presented as a two-bit phase index. The index selects one of four clock phases spaced a quarter oscillator period apart. Delaying the divided edge by index/4 periods cancels the sawtooth timing error that plain fractional division leaves behind. The edge is then corrected in time instead of through a voltage-domain correction. The index is a digital selector only. Choosing between real clocks happens outside this block.

Top module: `fracn_phase_ctrl`

## Requirements
- R1: While reset is held, mod_ctl and phase_idx are 0 and the accumulator is cleared. With en low during reset, div_pulse is 0.
- R2: div_pulse is high for exactly one clock cycle at a time. The first pulse after reset release comes on the first cycle in which en is high.
- R3: After a pulse, the next pulse comes N+c enabled cycles later. N is the n_int value sampled in the pulse cycle, and c is the modulus bit produced by that pulse.
- R4: frac holds the fraction numerator in quarters, with code k meaning k/4. At each pulse the accumulator becomes (acc+frac) mod 4, and mod_ctl becomes 1 exactly when acc+frac ≥ 4. With frac=1 from reset, mod_ctl runs 0,0,0,1 repeatedly.
- R5: phase_idx equals the new accumulator value from the cycle after a pulse onward. It changes on no other cycle. With frac=1 from reset it runs 1,2,3,0.
- R6: Take the enabled-cycle interval I between two pulses, the index p1 shown before the later pulse and the index p0 shown before the earlier pulse. Then 4·I + p1 − p0 equals 4·N + frac, using the values sampled at the earlier pulse.
- R7: Over any four consecutive divided periods with constant settings, the enabled-cycle total is 4·N + frac.
- R8: With frac=0, mod_ctl stays 0 and phase_idx keeps its value. From reset, that value is 0.
- R9: Values of n_int and frac outside pulse cycles have no effect on the outputs.
- R10: While en is low, div_pulse stays 0 and the count, mod_ctl and phase_idx hold.
- R11: n_int must be at least 4 in every pulse cycle. The minimum of 4 yields periods of 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per oscillator period |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advances the counter when high |
| n_int | input | N_W | Integer division ratio N, sampled at pulses |
| frac | input | 2 | Fraction numerator in quarters, sampled at pulses |
| div_pulse | output | 1 | One-cycle divided pulse |
| mod_ctl | output | 1 | 1 selects N+1 for the current period |
| phase_idx | output | 2 | Quarter-period phase selector |

## Verification
div_pulse is combinational from the count and en, so it is due in the same cycle as the terminal count. mod_ctl and phase_idx are registered and take their new values one cycle after the pulse. The next pulse is due N+c enabled cycles after the previous one. The bench drives inputs shortly after each rising edge and samples just after that, so every sample sees the current cycle. It compares the outputs against a model that applies the new accumulator value only from the following cycle. It also counts the enabled cycles down to the predicted pulse, and the interval and four-period totals are computed from the observed pulses alone.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int FRAC_W = 2;
  localparam int PHASES = 1 << FRAC_W;

  typedef struct packed {
    logic              carry;
    logic [FRAC_W-1:0] sum;
  } acc_step_t;

  // modulo-PHASES addition of the fraction into the accumulator
  function automatic acc_step_t acc_add(input logic [FRAC_W-1:0] acc,
                                        input logic [FRAC_W-1:0] frac);
    logic [FRAC_W:0] t;
    acc_step_t r;
    t = {1'b0, acc} + {1'b0, frac};
    r.carry = t[FRAC_W];
    r.sum   = t[FRAC_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              carry_nxt,
  output logic              mod_ctl,
  output logic [FRAC_W-1:0] phase_idx
);
  acc_step_t nxt;
  logic [FRAC_W-1:0] acc_q;
  logic              mod_q;

  always_comb nxt = acc_add(acc_q, frac_in);
  assign carry_nxt = nxt.carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      mod_q <= 1'b0;
    end else if (step) begin
      acc_q <= nxt.sum;
      mod_q <= nxt.carry;
    end
  end

  assign mod_ctl   = mod_q;
  assign phase_idx = acc_q;

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(phase_idx) && $stable(mod_ctl))); // R5
  AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && frac_in == '0) |=> (!mod_ctl && phase_idx == $past(phase_idx))); // R8
  AST_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ({mod_ctl, phase_idx} == (3'($past(phase_idx)) + 3'($past(frac_in))))); // R6
endmodule

// File: rtl/fracn_divcnt.sv
module fracn_divcnt #(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N_W-1:0] n_in,
  input  logic           carry_in,
  output logic           div_pulse
);
  localparam int CW = N_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload_w;
  logic          term;

  assign term      = (cnt_q == '0);
  assign reload_w  = CW'(n_in) + CW'(carry_in) - CW'(1);
  assign div_pulse = en & term;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (en) begin
      if (term)      cnt_q <= reload_w;
      else           cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R2
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/fracn_phase_ctrl.sv
module fracn_phase_ctrl
  import fracn_pkg::*;
#(
  parameter int N_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [N_W-1:0]    n_int,
  input  logic [FRAC_W-1:0] frac,
  output logic              div_pulse,
  output logic              mod_ctl,
  output logic [FRAC_W-1:0] phase_idx
);
  localparam int CW = N_W + 1;

  logic carry_w;

  fracn_accum u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (div_pulse),
    .frac_in   (frac),
    .carry_nxt (carry_w),
    .mod_ctl   (mod_ctl),
    .phase_idx (phase_idx)
  );

  fracn_divcnt #(.N_W(N_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .n_in      (n_int),
    .carry_in  (carry_w),
    .div_pulse (div_pulse)
  );

  // period checker: enabled cycles since the last pulse against the promised length
  logic [CW-1:0] since_q, gap_q;
  logic          seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
      gap_q   <= '0;
      seen_q  <= 1'b0;
    end else if (div_pulse) begin
      since_q <= '0;
      gap_q   <= CW'(n_int) + CW'(carry_w);
      seen_q  <= 1'b1;
    end else if (en) begin
      since_q <= since_q + CW'(1);
    end
  end

  AST_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && div_pulse) |-> ((since_q + CW'(1)) == gap_q)); // R3
  AST_N_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> (n_int >= N_W'(4))); // R11
endmodule

// File: tb/fracn_phase_ctrl_tb.sv
module fracn_phase_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NW = 8;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [NW-1:0] n_int = 8'd8;
  logic [1:0] frac = 2'd0;
  wire div_pulse, mod_ctl;
  wire [1:0] phase_idx;

  fracn_phase_ctrl #(.N_W(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .n_int(n_int), .frac(frac),
    .div_pulse(div_pulse), .mod_ctl(mod_ctl), .phase_idx(phase_idx)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, bad = 0;
  bit done = 0;
  int exp_mod, exp_ph, wait_cnt;
  int obs_int, pulses, prev_ph, n_last, f_last;
  int win_n, win_f, win_sum, win_cnt;

  function automatic int sum_q(int s, int f); return (s + f) % 4; endfunction
  function automatic int carry_q(int s, int f); return ((s + f) >= 4) ? 1 : 0; endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic model_clear();
    exp_mod = 0; exp_ph = 0; wait_cnt = 1;
    obs_int = 0; pulses = 0; prev_ph = 0; n_last = 0; f_last = 0;
    win_n = -1; win_f = -1; win_sum = 0; win_cnt = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
    chk(mod_ctl == 1'b0, "R1 mod in reset", int'(mod_ctl), 0);
    chk(phase_idx == 2'd0, "R1 phase in reset", int'(phase_idx), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_clear();
  endtask

  // one clock cycle: set inputs, sample, compare, advance to next edge
  task automatic cyc(input bit e, input int n, input int f, input string tag);
    bit exp_p;
    en = e; n_int = NW'(n); frac = 2'(f);
    #1;
    chk(mod_ctl == exp_mod[0], $sformatf("R4 mod_ctl [%s]", tag), int'(mod_ctl), exp_mod);
    chk(phase_idx == 2'(exp_ph), $sformatf("R5 phase_idx [%s]", tag), int'(phase_idx), exp_ph);
    if (e) wait_cnt--;
    exp_p = e && (wait_cnt == 0);
    chk(div_pulse == exp_p, $sformatf("R3 pulse timing [%s]", tag), int'(div_pulse), int'(exp_p));
    if (exp_p) begin
      exp_mod = carry_q(exp_ph, f);
      exp_ph  = sum_q(exp_ph, f);
      wait_cnt = n + exp_mod;
    end
    if (e) obs_int++;
    if (div_pulse) begin
      if (pulses >= 1) begin
        chk(4*obs_int + int'(phase_idx) - prev_ph == 4*n_last + f_last,
            $sformatf("R6 compensated spacing [%s]", tag),
            4*obs_int + int'(phase_idx) - prev_ph, 4*n_last + f_last);
        if (win_n == n_last && win_f == f_last) begin
          win_sum += obs_int; win_cnt++;
        end else begin
          win_n = n_last; win_f = f_last; win_sum = obs_int; win_cnt = 1;
        end
        if (win_cnt == 4) begin
          chk(win_sum == 4*win_n + win_f, $sformatf("R7 four-period total [%s]", tag),
              win_sum, 4*win_n + win_f);
          win_cnt = 0; win_sum = 0;
        end
      end
      prev_ph = int'(phase_idx); n_last = n; f_last = f;
      obs_int = 0; pulses++;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    model_clear();
    do_reset();
    // demo ratio 64 + 1/4, first pulse on first enabled cycle
    for (int i = 0; i < 64*4*6; i++) cyc(1'b1, 64, 1, "R2 demo");
    // zero fraction from reset
    do_reset();
    for (int i = 0; i < 200; i++) cyc(1'b1, 5, 0, "R8");
    // minimum N with each fraction
    for (int f = 1; f < 4; f++)
      for (int i = 0; i < 120; i++) cyc(1'b1, 4, f, "R11");
    // enable gaps mid-period
    for (int i = 0; i < 600; i++) cyc((i % 11) < 7, 9, 3, "R10");
    // junk settings except in pulse cycles
    for (int i = 0; i < 800; i++) begin
      if (wait_cnt == 1) cyc(1'b1, 6, 2, "R9");
      else cyc(1'b1, 4 + int'($urandom % 200), int'($urandom % 4), "R9");
    end
    // constrained random mix
    for (int i = 0; i < 30000; i++) begin
      bit e;
      int n, f;
      e = ($urandom % 10) != 0;
      n = 4 + int'($urandom % 30);
      f = int'($urandom % 4);
      if (($urandom % 100) < 70 && i > 0) begin n = n_last > 0 ? n_last : n; f = f_last; end
      cyc(e, n, f, "random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule